// File: doc/BRIEF.md
# Display Command Decoder Register File

This block sits behind the serial host interface of a dot-matrix display controller. It takes command bytes, one per cycle marked by a valid strobe, and turns them into the controller's configuration registers. Those registers are power-down, vertical/horizontal address stepping, instruction page, X and Y mirroring, display mode, read-modify-write enable, temperature coefficient, bias selection and the voltage-generator code. It also issues one-cycle load strobes, with values, for the RAM X and Y address counters.

The decode uses two pages. A page bit, written by the page-independent configuration command, selects either the basic table (display mode, address loads, read-modify-write) or the extended table (temperature, bias, voltage code). Within a page, an opcode is recognised by the position of the most significant set bit of the byte. Any byte that is reserved on the current page is dropped without touching any register. A packed status byte and a generator-enable flag are derived from the registers.

Top module: `disp_cmd_regs`

## Requirements
- R1: After the active-low reset, pwr_down=1, every other register is 0 (vert_mode, ext_page, mirror_x, mirror_y, disp_mode, rmw_en, temp_coef, bias_sel, vop_code, x_value, y_value), both strobes are 0, and status_byte=8'h01.
- R2: Byte 001abcde on either page sets mirror_x=a, mirror_y=b, pwr_down=c, vert_mode=d and ext_page=e, all in the same cycle.
- R3: Byte 8'h00 changes no register and pulses no strobe on either page.
- R4: On the basic page (ext_page=0), byte 00001d0e sets disp_mode={d,e}. The encoding is 00 blank, 10 normal, 01 all on, 11 inverse. Byte 00001x1x is reserved.
- R5: On the basic page, byte 0000001r sets rmw_en=r.
- R6: On the basic page, byte 1xxxxxxx with xxxxxxx <= X_MAX (default 101) loads x_value and raises x_load for exactly the cycle after the command. A larger value is ignored and produces no strobe.
- R7: On the basic page, byte 0100yyyy with yyyy <= Y_MAX (default 8) loads y_value and raises y_load for exactly the cycle after the command. A larger value is ignored and produces no strobe.
- R8: On the extended page (ext_page=1), byte 000001tt sets temp_coef=tt.
- R9: On the extended page, byte 00010bbb sets bias_sel=bbb.
- R10: On the extended page, byte 1vvvvvvv sets vop_code=vvvvvvv.
- R11: The reserved bytes are ignored and change no register or strobe. On the basic page these are 00000001, 000001xx, 00001x1x, 0001xxxx, 0101xxxx and 011xxxxx. On the extended page these are 00000001, 0000001x, 00001xxx, 00011xxx and 01xxxxxx.
- R12: hv_enable is 1 exactly when vop_code is non-zero and pwr_down is 0.
- R13: status_byte is {2'b00, disp_mode[1], disp_mode[0], mirror_x, mirror_y, 1'b0, pwr_down}.
- R14: A byte presented while cmd_valid is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte qualifier |
| cmd_byte | input | 8 | Command byte |
| pwr_down | output | 1 | Power-down state |
| vert_mode | output | 1 | 1 = vertical address stepping |
| ext_page | output | 1 | Instruction page, 1 = extended |
| mirror_x | output | 1 | Horizontal mirror |
| mirror_y | output | 1 | Vertical mirror |
| disp_mode | output | 2 | Display mode {d,e} |
| rmw_en | output | 1 | Read-modify-write enable |
| temp_coef | output | 2 | Temperature coefficient select |
| bias_sel | output | 3 | Bias system select |
| vop_code | output | 7 | Voltage generator code |
| hv_enable | output | 1 | Generator running flag |
| x_load | output | 1 | X address load strobe |
| x_value | output | 7 | X address to load |
| y_load | output | 1 | Y address load strobe |
| y_value | output | 4 | Y address to load |
| status_byte | output | 8 | Packed status for readback |

## Verification
A wrong page bit shows up on the very next command: the byte is routed to the other table, so either a register that should have moved stays put or a register from the other page moves. A decode that fires on a reserved or out-of-range byte disturbs a register or raises a strobe one cycle after the command. The bench therefore sweeps all 256 byte values on both pages and compares every output against an arithmetic model in the cycle after each command. A stuck register stays visible on its output, and on the status byte or generator flag, until the next write to it.

// File: rtl/disp_cmd_regs.sv
module disp_cmd_regs #(
  parameter int X_MAX = 101,
  parameter int Y_MAX = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  output logic       pwr_down,
  output logic       vert_mode,
  output logic       ext_page,
  output logic       mirror_x,
  output logic       mirror_y,
  output logic [1:0] disp_mode,
  output logic       rmw_en,
  output logic [1:0] temp_coef,
  output logic [2:0] bias_sel,
  output logic [6:0] vop_code,
  output logic       hv_enable,
  output logic       x_load,
  output logic [6:0] x_value,
  output logic       y_load,
  output logic [3:0] y_value,
  output logic [7:0] status_byte
);
  localparam logic [6:0] XLIM = 7'(X_MAX);
  localparam logic [3:0] YLIM = 4'(Y_MAX);

  wire basic = cmd_valid && !ext_page;
  wire extd  = cmd_valid &&  ext_page;

  wire op_func = cmd_valid && cmd_byte[7:5] == 3'b001;
  wire op_disp = basic && cmd_byte[7:3] == 5'b00001 && !cmd_byte[1];
  wire op_rmw  = basic && cmd_byte[7:1] == 7'b0000001;
  wire op_y    = basic && cmd_byte[7:4] == 4'b0100 && cmd_byte[3:0] <= YLIM;
  wire op_x    = basic && cmd_byte[7] && cmd_byte[6:0] <= XLIM;
  wire op_tc   = extd && cmd_byte[7:2] == 6'b000001;
  wire op_bias = extd && cmd_byte[7:3] == 5'b00010;
  wire op_vop  = extd && cmd_byte[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_down  <= 1'b1;
      vert_mode <= 1'b0;
      ext_page  <= 1'b0;
      mirror_x  <= 1'b0;
      mirror_y  <= 1'b0;
    end else if (op_func) begin
      mirror_x  <= cmd_byte[4];
      mirror_y  <= cmd_byte[3];
      pwr_down  <= cmd_byte[2];
      vert_mode <= cmd_byte[1];
      ext_page  <= cmd_byte[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_mode <= 2'b00;
      rmw_en    <= 1'b0;
    end else begin
      if (op_disp) disp_mode <= {cmd_byte[2], cmd_byte[0]};
      if (op_rmw)  rmw_en    <= cmd_byte[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_coef <= 2'b00;
      bias_sel  <= 3'b000;
      vop_code  <= 7'd0;
    end else begin
      if (op_tc)   temp_coef <= cmd_byte[1:0];
      if (op_bias) bias_sel  <= cmd_byte[2:0];
      if (op_vop)  vop_code  <= cmd_byte[6:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_load  <= 1'b0;
      y_load  <= 1'b0;
      x_value <= 7'd0;
      y_value <= 4'd0;
    end else begin
      x_load <= op_x;
      y_load <= op_y;
      if (op_x) x_value <= cmd_byte[6:0];
      if (op_y) y_value <= cmd_byte[3:0];
    end
  end

  assign hv_enable   = !pwr_down && (vop_code != 7'd0);
  assign status_byte = {2'b00, disp_mode, mirror_x, mirror_y, 1'b0, pwr_down};

  wire [19:0] cfg = {pwr_down, vert_mode, ext_page, mirror_x, mirror_y,
                     disp_mode, rmw_en, temp_coef, bias_sel, vop_code};

  assert_func_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_func |=> ext_page == $past(cmd_byte[0]) && pwr_down == $past(cmd_byte[2]));

  assert_nop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte == 8'h00) |=> $stable(cfg) && !x_load && !y_load);

  assert_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(cfg) && !x_load && !y_load);

  assert_xload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    x_load |-> x_value <= XLIM && $past(cmd_valid) && !$past(ext_page));

  assert_yload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    y_load |-> y_value <= YLIM && $past(cmd_valid) && !$past(ext_page));

  assert_strobes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({x_load, y_load}));

  assert_hv_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hv_enable) |-> $past(cmd_valid));
endmodule

// File: tb/sim_disp_cmd_regs.sv
module sim_disp_cmd_regs;
  localparam int CLK_PERIOD = 10;
  localparam int XM = 101;
  localparam int YM = 8;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic pwr_down, vert_mode, ext_page, mirror_x, mirror_y, rmw_en, hv_enable, x_load, y_load;
  logic [1:0] disp_mode, temp_coef;
  logic [2:0] bias_sel;
  logic [6:0] vop_code, x_value;
  logic [3:0] y_value;
  logic [7:0] status_byte;

  disp_cmd_regs #(.X_MAX(XM), .Y_MAX(YM)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .pwr_down(pwr_down), .vert_mode(vert_mode), .ext_page(ext_page),
    .mirror_x(mirror_x), .mirror_y(mirror_y), .disp_mode(disp_mode),
    .rmw_en(rmw_en), .temp_coef(temp_coef), .bias_sel(bias_sel),
    .vop_code(vop_code), .hv_enable(hv_enable), .x_load(x_load),
    .x_value(x_value), .y_load(y_load), .y_value(y_value),
    .status_byte(status_byte));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  logic m_pd = 1, m_v = 0, m_h = 0, m_mx = 0, m_my = 0, m_rm = 0, m_xl = 0, m_yl = 0;
  logic [1:0] m_de = 0, m_tc = 0;
  logic [2:0] m_bs = 0;
  logic [6:0] m_vop = 0, m_xv = 0;
  logic [3:0] m_yv = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(logic [7:0] b, logic h);
    if (b == 8'h00) return "R3";
    if (b[7:5] == 3'b001) return "R2";
    if (!h) begin
      if (b[7]) return "R6";
      if (b[7:4] == 4'b0100) return "R7";
      if (b[7:3] == 5'b00001 && !b[1]) return "R4";
      if (b[7:1] == 7'b0000001) return "R5";
    end else begin
      if (b[7]) return "R10";
      if (b[7:3] == 5'b00010) return "R9";
      if (b[7:2] == 6'b000001) return "R8";
    end
    return "R11";
  endfunction

  task automatic model(logic [7:0] b);
    int v;
    m_xl = 0; m_yl = 0;
    v = int'(b);
    if (v >= 32 && v < 64) begin
      m_mx = b[4]; m_my = b[3]; m_pd = b[2]; m_v = b[1]; m_h = b[0];
    end else if (!m_h) begin
      if (v >= 128 && (v - 128) <= XM) begin m_xl = 1; m_xv = b[6:0]; end
      else if (v >= 64 && v < 80 && (v - 64) <= YM) begin m_yl = 1; m_yv = b[3:0]; end
      else if (v >= 8 && v < 16 && ((v / 2) % 2) == 0) m_de = {b[2], b[0]};
      else if (v == 2 || v == 3) m_rm = b[0];
    end else begin
      if (v >= 128) m_vop = b[6:0];
      else if (v >= 16 && v < 24) m_bs = b[2:0];
      else if (v >= 4 && v < 8) m_tc = b[1:0];
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, 32'({pwr_down, vert_mode, ext_page, mirror_x, mirror_y, disp_mode,
                  rmw_en, temp_coef, bias_sel, vop_code}),
             32'({m_pd, m_v, m_h, m_mx, m_my, m_de, m_rm, m_tc, m_bs, m_vop}));
    chk("R6 x strobe", 32'({x_load, x_value}), 32'({m_xl, m_xv}));
    chk("R7 y strobe", 32'({y_load, y_value}), 32'({m_yl, m_yv}));
    chk("R12 hv_enable", 32'(hv_enable), 32'(!m_pd && m_vop != 0));
    chk("R13 status", 32'(status_byte), 32'({2'b00, m_de, m_mx, m_my, 1'b0, m_pd}));
  endtask

  task automatic send(logic [7:0] b);
    string t;
    t = tag_of(b, m_h);
    @(negedge clk);
    cmd_byte = b; cmd_valid = 1'b1;
    model(b);
    @(negedge clk);
    cmd_valid = 1'b0;
    check_all(t);
  endtask

  task automatic idle(logic [7:0] b);
    @(negedge clk);
    cmd_byte = b; cmd_valid = 1'b0;
    m_xl = 0; m_yl = 0;
    @(negedge clk);
    check_all("R14");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset cfg", 32'({pwr_down, vert_mode, ext_page, mirror_x, mirror_y, disp_mode,
                             rmw_en, temp_coef, bias_sel, vop_code}), 32'h80000);
    chk("R1 reset strobes", 32'({x_load, y_load, x_value, y_value}), 32'h0);
    chk("R1 reset status", 32'(status_byte), 32'h01);
    chk("R1 reset hv", 32'(hv_enable), 32'h0);

    for (int pg = 0; pg < 2; pg++) begin
      for (int b = 0; b < 256; b++) begin
        send(8'(32 + ((b % 8) << 2) + ((b / 8) % 2) * 2 + pg));
        send(8'(b));
        if (b % 37 == 0) idle(8'(255 - b));
      end
    end

    send(8'h21); send(8'h85); send(8'h20);
    chk("R12 hv on", 32'(hv_enable), 32'h1);
    send(8'h24);
    chk("R12 hv off in power-down", 32'(hv_enable), 32'h0);
    send(8'h0D);
    chk("R4 inverse", 32'(disp_mode), 32'h3);
    idle(8'h08);
    chk("R14 mode kept", 32'(disp_mode), 32'h3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule